// File: doc/BRIEF.md
# Serial Management Register Slave

This block is the management side of a 10/100 Ethernet physical-layer device. It watches the two-wire management bus, with a clock line (`mdc`) and a bidirectional data line (`mdio`), and decodes read and write frames into accesses on a 32-entry space of 16-bit registers. Both bus lines are oversampled in the system clock domain. The data line is split into an input, an output and an output enable, so that a pad at the chip boundary can build the tristate.

The block answers frames sent to its own 5-bit address. It takes that address from strap inputs, which it captures while the reset input is held. It also answers frames sent to address zero. Register 0, the control register, and register 1, the status register, live inside the block. Register 0 carries a self-clearing soft-reset bit, a self-clearing restart-negotiation bit and an isolate bit. The reserved entries are guarded: writes to them are dropped and reads return zero. All other entries go to a plain internal port, so that neighbouring logic can hold counters and configuration.

Top module: `mdio_mgmt_slave`

## Requirements
- R1: After reset `mdio_oe` is 0 and `ctrl_out` reads 16'h3000 (bit 13 speed select and bit 12 negotiation enable set). With a strapped address of zero it reads 16'h3400 instead.
- R2: A frame is accepted only after at least 32 consecutive ones are sampled on `mdio_in` before the start pattern 0,1. A frame with a shorter preamble neither drives the bus nor writes.
- R3: A frame is, in order, the start bits 0,1, an opcode (1,0 = read, 0,1 = write), a 5-bit device address, a 5-bit register address, two turnaround bits and 16 data bits, each field MSB first and sampled on rising `mdc`. On a matching read, `mdio_oe` stays low through the first turnaround bit and rises with `mdio_out` low for the second. The 16 data bits follow, and the bus is released after the last data bit.
- R4: A write to register 0 stores bits 15..7. Bits 6..0 always read 0, and `ctrl_out` reflects the stored value.
- R5: The block responds to frames whose device address equals the latched strap address or 00000. Frames to any other address neither drive `mdio_oe` nor change any register.
- R6: `strap_addr` is captured only while `rst_n` is low. Later changes on it have no effect on address matching.
- R7: When the latched address is 00000, bit 10 (isolate) of register 0 reads 1 and `ctrl_out[10]` is 1, whatever is written.
- R8: Writing 1 to bit 15 raises `ctrl_out[15]` for exactly one clock cycle. Register 0 then returns to its reset value, and bit 15 reads back 0.
- R9: Writing 1 to bit 9 raises `ctrl_out[9]` for exactly one clock cycle, after which it clears. The other written bits remain.
- R10: Register 1 is read-only and reads {0, ABILITY[3:0], 00000, `an_done`, `remote_fault`, 1, `link_up`, `jabber`, 1} from bit 15 down to bit 0. With the default ABILITY of 4'hF and all inputs low, that is 16'h7809.
- R11: Registers 7 to 17 and 29 to 31 read 0, and writes to them produce no `ext_wr` pulse.
- R12: Registers 2 to 6 and 18 to 28 are forwarded. A write gives a one-cycle `ext_wr` with `ext_addr` and `ext_wdata`, and a read returns `ext_rdata` for `ext_addr`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversamples the management bus |
| rst_n | input | 1 | Active-low reset; strap address captured while low |
| strap_addr | input | 5 | Device address strap inputs |
| mdc | input | 1 | Management bus clock |
| mdio_in | input | 1 | Management data from the pad |
| mdio_out | output | 1 | Management data driven toward the pad |
| mdio_oe | output | 1 | Output enable for the data pad |
| link_up | input | 1 | Link state shown in the status register |
| an_done | input | 1 | Negotiation complete, shown in the status register |
| remote_fault | input | 1 | Remote fault, shown in the status register |
| jabber | input | 1 | Jabber detected, shown in the status register |
| ctrl_out | output | 16 | Current control register value as read back |
| ext_addr | output | 5 | Register address for the internal port |
| ext_wr | output | 1 | One-cycle write strobe for forwarded registers |
| ext_wdata | output | 16 | Write data for forwarded registers |
| ext_rdata | input | 16 | Read data for the register at `ext_addr` |

## Verification
The case that is hardest to reach from the ports is the forced isolate bit. It appears only when the address latched during reset is zero, so the stimulus changes the straps and applies a second hardware reset partway through the run. It then talks to the block through broadcast address zero. A second awkward case is the one-cycle life of the self-clearing bits, which never show up in a bus read. The bench counts the clock cycles in which `ctrl_out[15]` and `ctrl_out[9]` are high, and it forces the preamble count below 32 by sending a zero just before the ones.

// File: rtl/mdio_mgmt_slave.sv
module mdio_mgmt_slave #(
  parameter logic [3:0] ABILITY = 4'hF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [4:0]  strap_addr,
  input  logic        mdc,
  input  logic        mdio_in,
  output logic        mdio_out,
  output logic        mdio_oe,
  input  logic        link_up,
  input  logic        an_done,
  input  logic        remote_fault,
  input  logic        jabber,
  output logic [15:0] ctrl_out,
  output logic [4:0]  ext_addr,
  output logic        ext_wr,
  output logic [15:0] ext_wdata,
  input  logic [15:0] ext_rdata
);
  localparam logic [15:0] CTL_DEF   = 16'h3000;
  localparam logic [15:0] CTL_WMASK = 16'hFF80;
  localparam logic [5:0]  PRE_LEN   = 6'd32;

  typedef enum logic [2:0] {S_PRE, S_ST, S_HDR, S_TA, S_DAT} st_t;

  st_t         st;
  logic [2:0]  mdc_s;
  logic [1:0]  dio_s;
  logic [5:0]  pcnt;
  logic [3:0]  bcnt;
  logic [10:0] hdr;
  logic [4:0]  rg, my_addr;
  logic        is_rd, is_wr, wr_go;
  logic [15:0] sh, wr_data, ctl, ctl_rd, stat, rsel;

  wire        rise   = mdc_s[1] & ~mdc_s[2];
  wire        bin    = dio_s[1];
  wire [11:0] hdr_n  = {hdr, bin};
  wire        hit    = (hdr_n[9:5] == my_addr) || (hdr_n[9:5] == 5'd0);
  wire        op_rd  = (hdr_n[11:10] == 2'b10);
  wire        op_wr  = (hdr_n[11:10] == 2'b01);
  wire        a_zero = (my_addr == 5'd0);
  wire        rsv    = (rg >= 5'd7 && rg <= 5'd17) || (rg >= 5'd29);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mdc_s <= '0;
      dio_s <= '0;
    end else begin
      mdc_s <= {mdc_s[1:0], mdc};
      dio_s <= {dio_s[0], mdio_in};
    end

  always_ff @(posedge clk)
    if (!rst_n) my_addr <= strap_addr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_PRE;  pcnt <= '0;  bcnt <= '0;  hdr <= '0;  rg <= '0;
      is_rd <= 1'b0;  is_wr <= 1'b0;  sh <= '0;
      mdio_oe <= 1'b0;  mdio_out <= 1'b0;  wr_go <= 1'b0;  wr_data <= '0;
    end else begin
      wr_go <= 1'b0;
      if (rise) begin
        case (st)
          S_PRE: begin
            if (bin) begin
              if (pcnt != PRE_LEN) pcnt <= pcnt + 6'd1;
            end else begin
              if (pcnt == PRE_LEN) st <= S_ST;
              pcnt <= '0;
            end
          end
          S_ST: begin
            bcnt <= '0;
            st   <= bin ? S_HDR : S_PRE;
          end
          S_HDR: begin
            hdr  <= hdr_n[10:0];
            bcnt <= bcnt + 4'd1;
            if (bcnt == 4'd11) begin
              bcnt  <= '0;
              rg    <= hdr_n[4:0];
              is_rd <= hit && op_rd;
              is_wr <= hit && op_wr;
              st    <= (op_rd || op_wr) ? S_TA : S_PRE;
            end
          end
          S_TA: begin
            if (bcnt == 4'd0) begin
              bcnt <= 4'd1;
              if (is_rd) begin
                mdio_oe  <= 1'b1;
                mdio_out <= 1'b0;
              end
            end else begin
              bcnt <= '0;
              st   <= S_DAT;
              sh   <= is_rd ? rsel : 16'h0000;
              if (is_rd) mdio_out <= rsel[15];
            end
          end
          S_DAT: begin
            bcnt <= bcnt + 4'd1;
            if (is_rd) begin
              sh       <= {sh[14:0], 1'b0};
              mdio_out <= sh[14];
            end else begin
              sh <= {sh[14:0], bin};
            end
            if (bcnt == 4'd15) begin
              st       <= S_PRE;
              pcnt     <= '0;
              bcnt     <= '0;
              mdio_oe  <= 1'b0;
              mdio_out <= 1'b0;
              if (is_wr) begin
                wr_go   <= 1'b1;
                wr_data <= {sh[14:0], bin};
              end
            end
          end
          default: st <= S_PRE;
        endcase
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                     ctl    <= CTL_DEF;
    else if (wr_go && rg == 5'd0)   ctl    <= wr_data & CTL_WMASK;
    else if (ctl[15])               ctl    <= CTL_DEF;
    else                            ctl[9] <= 1'b0;

  assign ctl_rd = ctl | {5'b0, a_zero, 10'b0};
  assign stat   = {1'b0, ABILITY, 5'b0, an_done, remote_fault, 1'b1, link_up, jabber, 1'b1};

  always_comb begin
    if (rg == 5'd0)      rsel = ctl_rd;
    else if (rg == 5'd1) rsel = stat;
    else if (rsv)        rsel = 16'h0000;
    else                 rsel = ext_rdata;
  end

  assign ctrl_out  = ctl_rd;
  assign ext_addr  = rg;
  assign ext_wdata = wr_data;
  assign ext_wr    = wr_go && (rg > 5'd1) && !rsv;

  p_ta_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdio_oe) |-> !mdio_out);
  p_oe_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mdio_oe |-> (st == S_TA || st == S_DAT));
  p_iso_forced_r7: assert property (@(posedge clk) disable iff (!rst_n)
    a_zero |-> ctrl_out[10]);
  p_soft_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_out[15] |=> ((ctrl_out & ~16'h0400) == CTL_DEF));
  p_restart_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_out[9] |=> !ctrl_out[9]);
  p_no_rsv_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ext_wr |-> !rsv);
endmodule

// File: tb/sim_mdio_mgmt_slave.sv
module sim_mdio_mgmt_slave;
  logic clk = 1'b0, rst_n = 1'b0, mdc = 1'b0, mdio_in = 1'b1;
  logic [4:0]  strap_addr = 5'd3;
  logic        link_up = 1'b0, an_done = 1'b0, remote_fault = 1'b0, jabber = 1'b0;
  logic        mdio_out, mdio_oe, ext_wr;
  logic [15:0] ctrl_out, ext_wdata, ext_rdata;
  logic [4:0]  ext_addr;
  logic [15:0] emem [32];
  int checks = 0, errors = 0, n15 = 0, n9 = 0;

  always #5 clk = ~clk;

  mdio_mgmt_slave u0 (
    .clk(clk), .rst_n(rst_n), .strap_addr(strap_addr), .mdc(mdc),
    .mdio_in(mdio_in), .mdio_out(mdio_out), .mdio_oe(mdio_oe),
    .link_up(link_up), .an_done(an_done), .remote_fault(remote_fault), .jabber(jabber),
    .ctrl_out(ctrl_out), .ext_addr(ext_addr), .ext_wr(ext_wr),
    .ext_wdata(ext_wdata), .ext_rdata(ext_rdata));

  assign ext_rdata = emem[ext_addr];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 32; i++) emem[i] <= 16'hA500 + 16'(i);
    end else if (ext_wr) emem[ext_addr] <= ext_wdata;
    if (rst_n && ctrl_out[15]) n15 <= n15 + 1;
    if (rst_n && ctrl_out[9])  n9  <= n9 + 1;
  end

  // {kind, phy, reg, data}; kind 0 write, 1 read with expected data, 2 read with no response
  localparam logic [27:0] VEC [18] = '{
    {2'd0, 5'd3, 5'd0,  16'h0100}, {2'd1, 5'd3, 5'd0,  16'h0100},
    {2'd0, 5'd0, 5'd0,  16'h21FF}, {2'd1, 5'd0, 5'd0,  16'h2180},
    {2'd1, 5'd3, 5'd1,  16'h7809}, {2'd0, 5'd3, 5'd4,  16'h01E1},
    {2'd1, 5'd3, 5'd4,  16'h01E1}, {2'd0, 5'd3, 5'd20, 16'hBEEF},
    {2'd1, 5'd3, 5'd20, 16'hBEEF}, {2'd0, 5'd3, 5'd8,  16'h1234},
    {2'd1, 5'd3, 5'd8,  16'h0000}, {2'd0, 5'd5, 5'd0,  16'h4000},
    {2'd1, 5'd3, 5'd0,  16'h2180}, {2'd2, 5'd5, 5'd0,  16'h0000},
    {2'd0, 5'd3, 5'd1,  16'hFFFF}, {2'd1, 5'd3, 5'd1,  16'h7809},
    {2'd1, 5'd3, 5'd30, 16'h0000}, {2'd1, 5'd3, 5'd18, 16'hA512}};

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic send_bit(input logic b, output logic o, output logic e);
    mdio_in = b;
    repeat (3) @(posedge clk);
    #1 o = mdio_out; e = mdio_oe;
    @(posedge clk); #1 mdc = 1'b1;
    repeat (4) @(posedge clk);
    #1 mdc = 1'b0;
  endtask

  task automatic xfer(input int pre, input logic rd, input logic [4:0] phy, input logic [4:0] ra,
                      input logic [15:0] wd, output logic [15:0] rdat, output logic ta_ok,
                      output logic drove, output logic released);
    logic o, e, e0;
    drove = 1'b0;
    send_bit(1'b0, o, e);
    for (int i = 0; i < pre; i++) send_bit(1'b1, o, e);
    send_bit(1'b0, o, e); send_bit(1'b1, o, e);
    send_bit(rd, o, e);   send_bit(!rd, o, e);
    for (int i = 4; i >= 0; i--) send_bit(phy[i], o, e);
    for (int i = 4; i >= 0; i--) begin send_bit(ra[i], o, e); drove |= e; end
    send_bit(1'b1, o, e0); drove |= e0;
    send_bit(!rd, o, e);   drove |= e;
    ta_ok = !e0 && e && !o;
    for (int i = 15; i >= 0; i--) begin
      send_bit(rd ? 1'b1 : wd[i], o, e);
      rdat[i] = o; drove |= e;
    end
    send_bit(1'b1, o, e);
    released = !e;
  endtask

  function automatic string req_of(input logic [1:0] k, input logic [4:0] p, input logic [4:0] r);
    if (k == 2'd2 || (r == 5'd0 && p == 5'd0)) return "R5";
    if (r == 5'd0) return "R4";
    if (r == 5'd1) return "R10";
    if ((r >= 5'd7 && r <= 5'd17) || r >= 5'd29) return "R11";
    return "R12";
  endfunction

  task automatic rd_chk(input string tag, input logic [4:0] phy, input logic [4:0] ra, input logic [15:0] exp);
    logic [15:0] d; logic t, dr, rl;
    xfer(32, 1'b1, phy, ra, 16'h0, d, t, dr, rl);
    chk(tag, d, exp);
    chk("R3", {14'b0, t, rl}, 16'h0003);
  endtask

  task automatic wr(input int pre, input logic [4:0] phy, input logic [4:0] ra, input logic [15:0] wd);
    logic [15:0] d; logic t, dr, rl;
    xfer(pre, 1'b0, phy, ra, wd, d, t, dr, rl);
  endtask

  task automatic nodrv(input string tag, input int pre, input logic [4:0] phy, input logic [4:0] ra);
    logic [15:0] d; logic t, dr, rl;
    xfer(pre, 1'b1, phy, ra, 16'h0, d, t, dr, rl);
    chk(tag, {15'b0, dr}, 16'h0000);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int c15, c9;
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (2) @(posedge clk); #1;
    chk("R1", {15'b0, mdio_oe}, 16'h0000);
    chk("R1", ctrl_out, 16'h3000);

    foreach (VEC[n]) begin
      logic [1:0] k = VEC[n][27:26];
      if (k == 2'd0) wr(32, VEC[n][25:21], VEC[n][20:16], VEC[n][15:0]);
      else if (k == 2'd1) rd_chk(req_of(k, VEC[n][25:21], VEC[n][20:16]), VEC[n][25:21], VEC[n][20:16], VEC[n][15:0]);
      else nodrv(req_of(k, VEC[n][25:21], VEC[n][20:16]), 32, VEC[n][25:21], VEC[n][20:16]);
    end
    chk("R11", emem[8], 16'hA508);

    link_up = 1'b1; an_done = 1'b1;
    rd_chk("R10", 5'd3, 5'd1, 16'h782D);
    link_up = 1'b0; an_done = 1'b0;

    c15 = n15;
    wr(32, 5'd3, 5'd0, 16'h8100);
    chk("R8", 16'(n15 - c15), 16'd1);
    rd_chk("R8", 5'd3, 5'd0, 16'h3000);

    c9 = n9;
    wr(32, 5'd3, 5'd0, 16'h1200);
    chk("R9", 16'(n9 - c9), 16'd1);
    rd_chk("R9", 5'd3, 5'd0, 16'h1000);

    wr(31, 5'd3, 5'd0, 16'h0100);
    rd_chk("R2", 5'd3, 5'd0, 16'h1000);
    nodrv("R2", 31, 5'd3, 5'd0);

    strap_addr = 5'd5;
    nodrv("R6", 32, 5'd5, 5'd0);
    rd_chk("R6", 5'd3, 5'd0, 16'h1000);

    strap_addr = 5'd0;
    #1 rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    strap_addr = 5'd9;
    repeat (2) @(posedge clk); #1;
    chk("R7", ctrl_out, 16'h3400);
    rd_chk("R7", 5'd0, 5'd0, 16'h3400);
    wr(32, 5'd0, 5'd0, 16'h3000);
    rd_chk("R7", 5'd0, 5'd0, 16'h3400);
    nodrv("R6", 32, 5'd9, 5'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule